// File: doc/BRIEF.md
# Accumulator Fetch-Decode-Execute Processor

A small multi-cycle processor built around one 8-bit accumulator. It steps through an explicit register-transfer sequence. A three-step fetch moves the program counter into the memory address register. It then reads the addressed word into the memory buffer register while the program counter advances. Last, it copies the buffer into the current instruction register. A decode step follows. Instructions with a direct operand take one extra memory step. An execute step updates the accumulator, the flags or the program counter.

Each instruction word is 8 bits: a 4-bit opcode in the upper nibble and a 4-bit operand in the lower nibble. Depending on the opcode, the operand is a zero-extended immediate value or the address of one of 16 memory words. The core drives a single-port synchronous memory. A read returns its data one clock after the address is presented, and writes take effect at the clock edge. The memory port has a fixed one-cycle latency and no handshake, so it applies no back-pressure: the memory must accept every access in the cycle it is presented. The accumulator, the flags and the current step are brought out as plain status pins.

Top module: `acc_fde_core`

## Requirements
- R1: While `rst_n` is low, the program counter, accumulator and flags are zero and `state_o` reads 0. After release, the first fetch presents address 0.
- R2: The fetch runs `state_o` 0 (FETCH1), 1 (FETCH2), 2 (FETCH3), then 3 (DECODE). FETCH1 shows the program counter on `mem_addr` with `mem_we` low. The program counter advances by one (modulo 16) during FETCH2, and the same fetch steps serve every opcode.
- R3: The opcode is instruction bits 7:4 and the operand is bits 3:0. Opcodes 0010, 0011, 1000 and 1010 are direct: they go DECODE, then 5 (MEM), then 4 (EXEC). All other opcodes go DECODE, then EXEC. EXEC returns to FETCH1.
- R4: Opcode 0001 loads the zero-extended operand into the accumulator. Opcode 0010 loads the memory word at the operand address.
- R5: Opcode 1001 adds the zero-extended operand to the accumulator, and 1000 adds the memory word at the operand address. The result is taken modulo 256 and the carry-out goes to the carry flag.
- R6: Opcode 1010 subtracts the memory word at the operand address from the accumulator, modulo 256. Carry is set when no borrow occurs, that is, when the accumulator is greater than or equal to the word.
- R7: Opcode 0011 writes the accumulator to the operand address. It does this during MEM with `mem_we` high, `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator. Accumulator and flags are unchanged. `mem_we` is never high in any other step.
- R8: `flags_o` bit 0 is zero (result equals 0), bit 1 is carry, and bit 2 is negative (result bit 7). The flags change only at the end of EXEC, and only for opcodes 0001, 0010, 1000, 1001 and 1010. Loads clear carry.
- R9: Opcode 1100 sets the program counter to the operand. Opcode 1101 does so only when the zero flag is set; otherwise execution continues in sequence.
- R10: Opcode 1111 enters `state_o` 6 (HALT) after its EXEC step and stays there, with `mem_we` low, until reset. Opcode 0000 and the unassigned opcodes change no visible state.
- R11: The address is presented one step ahead of the data capture. The instruction word is addressed in FETCH1 and captured in FETCH2. A direct operand's address is on `mem_addr` during DECODE and its data is captured during MEM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 4 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 3 | {negative, carry, zero} |
| state_o | output | 3 | Current step of the instruction sequence |

## Verification
Non-direct instructions take five clocks and direct ones take six. A result written by EXEC is visible on `acc_o` and `flags_o` in the following FETCH1. A store is on the memory pins throughout its MEM cycle and lands in memory at the end of that cycle. The bench carries its own instruction-level model that advances one step per rising edge. It compares every output on the falling edge that follows, so each expected value is sampled in exactly the cycle the register chain delivers it. Final memory contents and the fetched-address trace add directed checks for stores, jumps and halting.

// File: rtl/acc_fde_pkg.sv
package acc_fde_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    ST_F1   = 3'd0,
    ST_F2   = 3'd1,
    ST_F3   = 3'd2,
    ST_DEC  = 3'd3,
    ST_EXEC = 3'd4,
    ST_MEM  = 3'd5,
    ST_HALT = 3'd6
  } fde_state_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_LDD  = 4'h2,
    OP_STD  = 4'h3,
    OP_ADDD = 4'h8,
    OP_ADDI = 4'h9,
    OP_SUBD = 4'hA,
    OP_JMP  = 4'hC,
    OP_JZ   = 4'hD,
    OP_HLT  = 4'hF
  } opc_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_fn_e;

  typedef struct packed {
    logic neg;
    logic carry;
    logic zero;
  } flags_t;

  function automatic logic op_is_direct(input logic [OPC_W-1:0] op);
    return (op == OP_LDD) || (op == OP_STD) || (op == OP_ADDD) || (op == OP_SUBD);
  endfunction

  function automatic logic op_sets_flags(input logic [OPC_W-1:0] op);
    return (op == OP_LDI) || (op == OP_LDD) || (op == OP_ADDD) ||
           (op == OP_ADDI) || (op == OP_SUBD);
  endfunction
endpackage

// File: rtl/acc_fde_ctrl.sv
module acc_fde_ctrl
  import acc_fde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output fde_state_e       state
);
  fde_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_F1:   state_nx = ST_F2;
      ST_F2:   state_nx = ST_F3;
      ST_F3:   state_nx = ST_DEC;
      ST_DEC:  state_nx = op_is_direct(opcode) ? ST_MEM : ST_EXEC;
      ST_MEM:  state_nx = ST_EXEC;
      ST_EXEC: state_nx = (opcode == OP_HLT) ? ST_HALT : ST_F1;
      ST_HALT: state_nx = ST_HALT;
      default: state_nx = ST_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_F1;
    else        state <= state_nx;
  end

  // R2: fetch order is fixed
  p_fetch_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F1) |=> (state == ST_F2));
  p_fetch_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F2) |=> (state == ST_F3) ##1 (state == ST_DEC));
  // R3: only direct opcodes visit MEM, and MEM is always followed by EXEC
  p_mem_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM) |-> op_is_direct(opcode));
  p_mem_to_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM) |=> (state == ST_EXEC));
  // R10: halt is sticky until reset
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/acc_fde_alu.sv
module acc_fde_alu
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [DATA_W:0] wide;

  always_comb begin
    unique case (fn)
      ALU_ADD: wide = {1'b0, a} + {1'b0, b};
      ALU_SUB: wide = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
      default: wide = {1'b0, b};
    endcase
    res  = wide[DATA_W-1:0];
    cout = wide[DATA_W];
  end
endmodule

// File: rtl/acc_fde_datapath.sv
module acc_fde_datapath
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fde_state_e        state,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] acc,
  output flags_t            flags
);
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, cir;
  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] imm, alu_b, alu_res;
  logic              alu_c;
  alu_fn_e           alu_fn;

  assign opcode  = cir[DATA_W-1 -: OPC_W];
  assign operand = cir[ADDR_W-1:0];
  assign imm     = {{OPC_W{1'b0}}, operand};

  // Look-ahead address: steps that load the MAR already drive its new value
  always_comb begin
    unique case (state)
      ST_F1:   mem_addr = pc;
      ST_DEC:  mem_addr = operand;
      default: mem_addr = mar;
    endcase
  end

  assign mem_we    = (state == ST_MEM) && (opcode == OP_STD);
  assign mem_wdata = mbr;

  always_comb begin
    unique case (opcode)
      OP_ADDD, OP_ADDI: alu_fn = ALU_ADD;
      OP_SUBD:          alu_fn = ALU_SUB;
      default:          alu_fn = ALU_PASS;
    endcase
    alu_b = ((opcode == OP_LDI) || (opcode == OP_ADDI)) ? imm : mbr;
  end

  acc_fde_alu #(.DATA_W(DATA_W)) u_alu (
    .a(acc), .b(alu_b), .fn(alu_fn), .res(alu_res), .cout(alu_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      mar   <= '0;
      mbr   <= '0;
      cir   <= '0;
      acc   <= '0;
      flags <= '0;
    end else begin
      unique case (state)
        ST_F1: mar <= pc;
        ST_F2: begin
          pc  <= pc + 1'b1;
          mbr <= mem_rdata;
        end
        ST_F3: cir <= mbr;
        ST_DEC: begin
          if (op_is_direct(opcode)) mar <= operand;
          if (opcode == OP_STD)     mbr <= acc;
        end
        ST_MEM: if (opcode != OP_STD) mbr <= mem_rdata;
        ST_EXEC: begin
          if (op_sets_flags(opcode)) begin
            acc   <= alu_res;
            flags <= '{neg: alu_res[DATA_W-1], carry: alu_c, zero: (alu_res == '0)};
          end
          if ((opcode == OP_JMP) || ((opcode == OP_JZ) && flags.zero)) pc <= operand;
        end
        default: ;
      endcase
    end
  end

  // R2: program counter advances during the second fetch step
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F2) |=> (pc == $past(pc) + 1'b1));
  // R2: instruction register takes the buffered word
  p_cir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F3) |=> (cir == $past(mbr)));
  // R7: write strobe only during MEM, addressed by the MAR
  p_we_in_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((state == ST_MEM) && (mem_addr == mar) && (mem_wdata == acc)));
  // R8: flags hold outside EXEC
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EXEC) |=> $stable(flags));
  // R7: a store leaves the accumulator alone
  p_store_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_EXEC) && (opcode == OP_STD)) |=> $stable(acc));
  // R11: MBR captures memory in the step after the address was shown
  p_fetch_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F2) |=> (mbr == $past(mem_rdata)));
endmodule

// File: rtl/acc_fde_core.sv
module acc_fde_core
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_o,
  output logic [2:0]        flags_o,
  output logic [2:0]        state_o
);
  fde_state_e       state;
  logic [OPC_W-1:0] opcode;
  flags_t           flags;

  acc_fde_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .state(state)
  );

  acc_fde_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .opcode(opcode), .acc(acc_o), .flags(flags)
  );

  assign flags_o = flags;
  assign state_o = state;
endmodule

// File: tb/acc_fde_core_test.sv
module acc_fde_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] acc_o;
  logic [2:0] flags_o, state_o;

  int errors = 0;
  int checks = 0;

  always #2ns clk = ~clk;

  acc_fde_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .acc_o(acc_o),
    .flags_o(flags_o), .state_o(state_o)
  );

  // Bench memory: synchronous, one-cycle read, image reloaded during reset
  logic [7:0] img [16];
  logic [7:0] mem [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Instruction-level reference model, one step per rising edge
  int m_state, m_pc, m_acc, m_flags, m_ir;
  int ref_mem [16];
  bit fetched [16];

  function automatic bit is_dir(input int op);
    return (op == 2) || (op == 3) || (op == 8) || (op == 10);
  endfunction

  task automatic setf(input int r, input int c);
    m_acc   = r;
    m_flags = (((r >> 7) & 1) << 2) | (c << 1) | ((r == 0) ? 1 : 0);
  endtask

  task automatic model_exec();
    int op, opd, s;
    op  = m_ir >> 4;
    opd = m_ir & 15;
    case (op)
      1:  setf(opd, 0);
      2:  setf(ref_mem[opd], 0);
      8:  begin s = m_acc + ref_mem[opd];       setf(s & 255, s >> 8); end
      9:  begin s = m_acc + opd;                setf(s & 255, s >> 8); end
      10: begin s = m_acc + (255 - ref_mem[opd]) + 1; setf(s & 255, s >> 8); end
      12: m_pc = opd;
      13: if ((m_flags & 1) != 0) m_pc = opd;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pc = 0; m_acc = 0; m_flags = 0; m_ir = 0;
      for (int i = 0; i < 16; i++) ref_mem[i] = img[i];
    end else begin
      case (m_state)
        0: m_state = 1;
        1: begin m_ir = ref_mem[m_pc]; m_pc = (m_pc + 1) % 16; m_state = 2; end
        2: m_state = 3;
        3: m_state = is_dir(m_ir >> 4) ? 5 : 4;
        5: begin
          if ((m_ir >> 4) == 3) ref_mem[m_ir & 15] = m_acc;
          m_state = 4;
        end
        4: begin model_exec(); m_state = ((m_ir >> 4) == 15) ? 6 : 0; end
        default: ;
      endcase
    end
  end

  // Compare on the falling edge after each step
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = (m_state == 5) && ((m_ir >> 4) == 3);
      chk(state_o == m_state, "R3 step sequence", state_o, m_state);
      chk(acc_o == m_acc, "R4 accumulator", acc_o, m_acc);
      chk(flags_o == m_flags, "R8 flags", flags_o, m_flags);
      chk(mem_we == exp_we, "R7 write strobe", mem_we, exp_we);
      if (m_state == 0) begin
        chk(mem_addr == m_pc, "R2 fetch address", mem_addr, m_pc);
        fetched[mem_addr] = 1'b1;
      end
      if (m_state == 3 && is_dir(m_ir >> 4))
        chk(mem_addr == (m_ir & 15), "R11 operand address in decode", mem_addr, m_ir & 15);
      if (exp_we) begin
        chk(mem_addr == (m_ir & 15), "R7 store address", mem_addr, m_ir & 15);
        chk(mem_wdata == m_acc, "R7 store data", mem_wdata, m_acc);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) fetched[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R1 reset step", state_o, 0);
    chk(acc_o == 8'd0, "R1 reset accumulator", acc_o, 0);
    chk(flags_o == 3'd0, "R1 reset flags", flags_o, 0);
    chk(mem_addr == 4'd0, "R1 first fetch address", mem_addr, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (state_o != 3'd6 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(state_o == 3'd6, "R10 reaches halt", state_o, 6);
    repeat (8) begin
      @(negedge clk);
      chk(state_o == 3'd6 && !mem_we, "R10 halt holds", state_o, 6);
    end
  endtask

  initial begin
    #(4ns * 20000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Program 1: immediate load, add with carry, store, subtract to zero, jumps
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h19;  img[1] = 8'h8E;  img[2] = 8'h3F;  img[3] = 8'hAF;
    img[4] = 8'hD7;  img[5] = 8'h13;  img[6] = 8'hF0;  img[7] = 8'h95;
    img[8] = 8'h8D;  img[9] = 8'hD5;  img[10] = 8'h00; img[11] = 8'hC6;
    img[13] = 8'h80; img[14] = 8'hF8;
    do_reset();
    run_to_halt();
    chk(acc_o == 8'h85, "R5 final accumulator", acc_o, 8'h85);
    chk(flags_o == 3'b100, "R8 final flags negative", flags_o, 3'b100);
    chk(mem[15] == 8'h01, "R7 stored word", mem[15], 8'h01);
    chk(mem[14] == 8'hF8, "R7 other word untouched", mem[14], 8'hF8);
    chk(!fetched[5], "R9 taken JZ skips word 5", fetched[5], 0);
    chk(fetched[10], "R9 untaken JZ falls through", fetched[10], 1);
    chk(!fetched[12], "R9 JMP lands on halt", fetched[12], 0);

    // Program 2: direct load of zero, unassigned opcode, borrow, store
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h2A; img[1] = 8'h70; img[2] = 8'hAB; img[3] = 8'h3C;
    img[4] = 8'hF0; img[11] = 8'h01;
    do_reset();
    run_to_halt();
    chk(acc_o == 8'hFF, "R6 borrow result", acc_o, 8'hFF);
    chk(flags_o == 3'b100, "R6 borrow clears carry", flags_o, 3'b100);
    chk(mem[12] == 8'hFF, "R7 stored borrow result", mem[12], 8'hFF);
    chk(fetched[4] && !fetched[5], "R10 unassigned opcode falls through", fetched[5], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule